// File: doc/BRIEF.md
# Comma-Aligning Deserializer with Split-Phase Word Clocks

This block sits behind a clock and data recovery front end. It takes one recovered bit per fast-clock cycle and assembles the bits into 10-bit code groups. It does not decode the 8b/10b groups. It watches the incoming stream for the 7-bit comma pattern, in either running-disparity polarity. When it finds a comma, it moves the word boundary so that the comma sits at the start of a code group. Each completed group is presented on a 10-bit output. A flag marks the groups that hold a comma.

The block produces two half-rate word clocks that are always complementary. Each new word appears together with a rising edge on one of them, and the two clocks take turns: the first word after reset goes out with the A clock, the next with the B clock, and so on. A downstream capture stage can therefore latch words on either clock at half the word rate.

A loopback select feeds the local transmit-side serial bit into the receive path in place of the line bit. An enable input turns comma search and realignment on or off. While comma search is off, the current word boundary is kept and the flag is held low.

Top module: `deser_align_top`

## Requirements
- R1: A synchronous reset drives `word_out` to 0, `comma_flag` to 0, `wclk_a` to 0 and `wclk_b` to 1, and clears the bit count.
- R2: Bits arrive one per `clk` cycle, and the first-arriving bit of a group lands in `word_out[0]`. With no comma found, a new word is produced every 10 bits, and the first word is produced on the 10th bit after reset is released.
- R3: A comma is a window whose seven first-arriving bits, in arrival order, are 0,0,1,1,1,1,1 (that is, `word[6:0]` = 7'b1111100) or the complement 1,1,0,0,0,0,0 (`word[6:0]` = 7'b0000011). Once at least 10 bits have arrived since reset, either pattern starts alignment while `comma_en` is 1.
- R4: When a comma is found at a new offset, the word holding it is output on the cycle its 10th bit arrives. The bits of the interrupted group are dropped, so no partial word is emitted, and the following words fall every 10 bits from the comma word.
- R5: `comma_flag` is 1 with a word that was aligned on a comma, and it is 0 with every other word.
- R6: While `comma_en` is 0, no realignment takes place. `comma_flag` is 0 from the cycle after `comma_en` is sampled low.
- R7: Out of reset, `wclk_a` and `wclk_b` are always complementary.
- R8: Every new word is accompanied by exactly one rising word-clock edge, and the edges alternate: `wclk_a` rises with the first word after reset, then `wclk_b`, then `wclk_a` again.
- R9: When `loop_en` is 1, the bits are taken from `tx_bit` and `line_bit` is ignored. When `loop_en` is 0, the bits are taken from `line_bit` and `tx_bit` is ignored.
- R10: `word_out` changes only on cycles where a new word is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one serial bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| line_bit | input | 1 | Recovered bit from the line |
| tx_bit | input | 1 | Local transmit-side serial bit, used in loopback |
| loop_en | input | 1 | 1 selects `tx_bit` as the bit source |
| comma_en | input | 1 | 1 enables comma search and realignment |
| word_out | output | 10 | Aligned code group, bit 0 arrived first |
| comma_flag | output | 1 | Current word is comma-aligned |
| wclk_a | output | 1 | Half-rate word clock, phase A |
| wclk_b | output | 1 | Half-rate word clock, phase B, complement of A |

## Verification
A word, its flag and the matching word-clock edge all appear at the same `clk` edge: the one that samples the group's 10th bit. There is no further pipeline stage behind it. The flag reacts to `comma_en` going low at the first edge that samples the low level. The bench drives each bit on a falling edge and checks the outputs at the next falling edge, so every check falls half a cycle after the edge that is meant to update the outputs. The stable-word checks between emissions are taken at those same sampling points.

// File: rtl/deser_pkg.sv
package deser_pkg;

    // Default geometry of a code group and of the alignment marker.
    localparam int unsigned DEF_WORD_W  = 10;
    localparam int unsigned DEF_COMMA_W = 7;

    // Marker bits in arrival order: bit i is the i-th bit received.
    // Arrival sequence 0,0,1,1,1,1,1 gives 7'b1111100.
    localparam logic [DEF_COMMA_W-1:0] DEF_COMMA_PAT = 7'b1111100;

endpackage

// File: rtl/deser_src_sel.sv
module deser_src_sel (
    input  logic loop_en,
    input  logic tx_bit,
    input  logic line_bit,
    output logic src_bit
);

    // Loopback swaps the receive source for the local transmit stream.
    always_comb begin
        if (loop_en) begin
            src_bit = tx_bit;
        end else begin
            src_bit = line_bit;
        end
    end

endmodule

// File: rtl/deser_comma_det.sv
module deser_comma_det #(
    parameter int unsigned               COMMA_W   = deser_pkg::DEF_COMMA_W,
    parameter logic [COMMA_W-1:0]        COMMA_PAT = deser_pkg::DEF_COMMA_PAT
) (
    input  logic [COMMA_W-1:0] win_lo,
    output logic               hit_pos,
    output logic               hit_neg
);

    logic [COMMA_W-1:0] eq_pos;
    logic [COMMA_W-1:0] eq_neg;

    // Per-bit compare against the marker and its complement.
    for (genvar i = 0; i < COMMA_W; i++) begin : g_bit
        assign eq_pos[i] = (win_lo[i] == COMMA_PAT[i]);
        assign eq_neg[i] = (win_lo[i] != COMMA_PAT[i]);
    end

    assign hit_pos = &eq_pos;
    assign hit_neg = &eq_neg;

endmodule

// File: rtl/deser_phase_gen.sv
module deser_phase_gen (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic clk_a,
    output logic clk_b
);

    typedef struct packed {
        logic a;
        logic b;
    } ph_t;

    ph_t ph_d;
    ph_t ph_q;

    // Both phases flip together on every emitted word.
    always_comb begin
        ph_d = ph_q;
        if (adv) begin
            ph_d.a = ~ph_q.a;
            ph_d.b = ~ph_q.b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= '{a: 1'b0, b: 1'b1};
        end else begin
            ph_q <= ph_d;
        end
    end

    assign clk_a = ph_q.a;
    assign clk_b = ph_q.b;

endmodule

// File: rtl/deser_align_top.sv
module deser_align_top #(
    parameter int unsigned        WORD_W    = deser_pkg::DEF_WORD_W,
    parameter int unsigned        COMMA_W   = deser_pkg::DEF_COMMA_W,
    parameter logic [COMMA_W-1:0] COMMA_PAT = deser_pkg::DEF_COMMA_PAT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_bit,
    input  logic              tx_bit,
    input  logic              loop_en,
    input  logic              comma_en,
    output logic [WORD_W-1:0] word_out,
    output logic              comma_flag,
    output logic              wclk_a,
    output logic              wclk_b
);

    localparam int unsigned        CNT_W    = $clog2(WORD_W);
    localparam logic [CNT_W-1:0]   LAST_IDX = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] win;     // sliding window, [0] oldest
        logic [CNT_W-1:0]  cnt;     // bits since current boundary
        logic              primed;  // a full window has been seen
        logic [WORD_W-1:0] word;
        logic              flag;
    } st_t;

    st_t st_d;
    st_t st_q;

    logic              src_bit;
    logic [WORD_W-1:0] win_nx;
    logic              hit_pos;
    logic              hit_neg;
    logic              at_bound;
    logic              hit;
    logic              emit;

    deser_src_sel u_src (
        .loop_en  (loop_en),
        .tx_bit   (tx_bit),
        .line_bit (line_bit),
        .src_bit  (src_bit)
    );

    assign win_nx = {src_bit, st_q.win[WORD_W-1:1]};

    deser_comma_det #(
        .COMMA_W   (COMMA_W),
        .COMMA_PAT (COMMA_PAT)
    ) u_det (
        .win_lo  (win_nx[COMMA_W-1:0]),
        .hit_pos (hit_pos),
        .hit_neg (hit_neg)
    );

    always_comb begin
        st_d     = st_q;
        st_d.win = win_nx;
        at_bound = (st_q.cnt == LAST_IDX);
        // Search only once the window holds real bits only.
        hit      = comma_en && (st_q.primed || at_bound) && (hit_pos || hit_neg);
        emit     = at_bound || hit;
        if (emit) begin
            st_d.word   = win_nx;
            st_d.flag   = hit;
            st_d.cnt    = '0;
            st_d.primed = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.flag = st_q.flag && comma_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    deser_phase_gen u_ph (
        .clk   (clk),
        .rst   (rst),
        .adv   (emit),
        .clk_a (wclk_a),
        .clk_b (wclk_b)
    );

    assign word_out   = st_q.word;
    assign comma_flag = st_q.flag;

endmodule

// File: rtl/deser_align_chk.sv
module deser_align_chk #(
    parameter int unsigned        WORD_W    = deser_pkg::DEF_WORD_W,
    parameter int unsigned        COMMA_W   = deser_pkg::DEF_COMMA_W,
    parameter logic [COMMA_W-1:0] COMMA_PAT = deser_pkg::DEF_COMMA_PAT
) (
    input logic              clk,
    input logic              rst,
    input logic              comma_en,
    input logic [WORD_W-1:0] word_out,
    input logic              comma_flag,
    input logic              wclk_a,
    input logic              wclk_b
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (word_out == '0 && !comma_flag && !wclk_a && wclk_b));

    a_r7_clk_complement: assert property (@(posedge clk) disable iff (rst)
        (wclk_a != wclk_b));

    a_r10_word_on_edge: assert property (@(posedge clk) disable iff (rst)
        !$stable(word_out) |-> ($rose(wclk_a) || $rose(wclk_b)));

    a_r5_flag_has_comma: assert property (@(posedge clk) disable iff (rst)
        comma_flag |-> (word_out[COMMA_W-1:0] == COMMA_PAT ||
                        word_out[COMMA_W-1:0] == ~COMMA_PAT));

    a_r6_flag_low_off: assert property (@(posedge clk) disable iff (rst)
        !comma_en |=> !comma_flag);

    a_r8_flag_with_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(comma_flag) |-> ($rose(wclk_a) || $rose(wclk_b)));

endmodule

bind deser_align_top deser_align_chk #(
    .WORD_W    (WORD_W),
    .COMMA_W   (COMMA_W),
    .COMMA_PAT (COMMA_PAT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .comma_en   (comma_en),
    .word_out   (word_out),
    .comma_flag (comma_flag),
    .wclk_a     (wclk_a),
    .wclk_b     (wclk_b)
);

// File: tb/sim_deser_align_top.sv
module sim_deser_align_top;

    localparam int CLK_PERIOD = 10;

    // Code groups, bit i sent i-th.
    localparam logic [9:0] K_POS  = 10'b0101111100;  // comma, 0,0,1,1,1,1,1 first
    localparam logic [9:0] K_NEG  = 10'b1010000011;  // comma, 1,1,0,0,0,0,0 first
    localparam logic [9:0] D_ALT  = 10'b1010101010;
    localparam logic [9:0] W_ONE  = 10'b1001100111;
    localparam logic [9:0] W_TWO  = 10'b0011010010;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_bit = 1'b0;
    logic       tx_bit = 1'b1;
    logic       loop_en = 1'b0;
    logic       comma_en = 1'b0;
    logic [9:0] word_out;
    logic       comma_flag;
    logic       wclk_a;
    logic       wclk_b;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    deser_align_top u0 (
        .clk        (clk),
        .rst        (rst),
        .line_bit   (line_bit),
        .tx_bit     (tx_bit),
        .loop_en    (loop_en),
        .comma_en   (comma_en),
        .word_out   (word_out),
        .comma_flag (comma_flag),
        .wclk_a     (wclk_a),
        .wclk_b     (wclk_b)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Drive one bit at a falling edge; return at the next falling edge.
    task automatic push(input logic b);
        if (loop_en) begin
            tx_bit   = b;
            line_bit = ~b;
        end else begin
            line_bit = b;
            tx_bit   = ~b;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push_word(input logic [9:0] w);
        for (int i = 0; i < 10; i++) push(w[i]);
    endtask

    task automatic t_reset();
        loop_en = 1'b0;
        comma_en = 1'b0;
        do_reset();
        check("R1 word", 32'(word_out), 32'h0);
        check("R1 flag", 32'(comma_flag), 32'h0);
        check("R1 wclk_a", 32'(wclk_a), 32'h0);
        check("R1 wclk_b", 32'(wclk_b), 32'h1);
    endtask

    task automatic t_free_run();
        comma_en = 1'b0;
        loop_en = 1'b0;
        do_reset();
        for (int i = 0; i < 9; i++) push(W_ONE[i]);
        check("R2 no word before 10th bit", 32'(word_out), 32'h0);
        push(W_ONE[9]);
        check("R2 first word", 32'(word_out), 32'(W_ONE));
        check("R8 first edge on A", 32'({wclk_a, wclk_b}), 32'h2);
        for (int i = 0; i < 5; i++) push(W_TWO[i]);
        check("R10 word held mid-group", 32'(word_out), 32'(W_ONE));
        for (int i = 5; i < 10; i++) push(W_TWO[i]);
        check("R2 second word", 32'(word_out), 32'(W_TWO));
        check("R8 second edge on B", 32'({wclk_a, wclk_b}), 32'h1);
        check("R7 complementary", 32'(wclk_a ^ wclk_b), 32'h1);
    endtask

    task automatic t_align_pos();
        comma_en = 1'b1;
        loop_en = 1'b0;
        do_reset();
        push(1'b1); push(1'b0); push(1'b1);
        for (int i = 0; i < 7; i++) push(K_POS[i]);
        check("R4 old-boundary word", 32'(word_out), 32'h3E5);
        check("R5 no flag on plain word", 32'(comma_flag), 32'h0);
        push(K_POS[7]); push(K_POS[8]);
        check("R4 no partial word", 32'(word_out), 32'h3E5);
        check("R8 still on A", 32'({wclk_a, wclk_b}), 32'h2);
        push(K_POS[9]);
        check("R3 comma word aligned", 32'(word_out), 32'(K_POS));
        check("R5 flag on comma", 32'(comma_flag), 32'h1);
        check("R8 comma edge on B", 32'({wclk_a, wclk_b}), 32'h1);
        push_word(D_ALT);
        check("R4 next word 10 bits on", 32'(word_out), 32'(D_ALT));
        check("R5 flag cleared", 32'(comma_flag), 32'h0);
        check("R8 back on A", 32'({wclk_a, wclk_b}), 32'h2);
    endtask

    task automatic t_align_neg();
        logic [5:0] junk;
        junk = 6'b010110;
        comma_en = 1'b1;
        loop_en = 1'b0;
        do_reset();
        for (int i = 0; i < 6; i++) push(junk[i]);
        for (int i = 0; i < 9; i++) push(K_NEG[i]);
        check("R4 held before complement comma", 32'(word_out), 32'h0D6);
        push(K_NEG[9]);
        check("R3 complement comma aligned", 32'(word_out), 32'(K_NEG));
        check("R5 flag on complement comma", 32'(comma_flag), 32'h1);
        push_word(D_ALT);
        check("R4 data after complement comma", 32'(word_out), 32'(D_ALT));
    endtask

    task automatic t_disable();
        comma_en = 1'b1;
        loop_en = 1'b0;
        do_reset();
        push_word(K_POS);
        check("R3 comma at offset 0", 32'(word_out), 32'(K_POS));
        check("R5 flag at offset 0", 32'(comma_flag), 32'h1);
        comma_en = 1'b0;
        push(1'b1);
        check("R6 flag drops when off", 32'(comma_flag), 32'h0);
        check("R10 word kept", 32'(word_out), 32'(K_POS));
        push(1'b0); push(1'b1);
        for (int i = 0; i < 7; i++) push(K_POS[i]);
        check("R6 boundary kept", 32'(word_out), 32'h3E5);
        push(K_POS[7]); push(K_POS[8]); push(K_POS[9]);
        check("R6 no realign while off", 32'(word_out), 32'h3E5);
        check("R6 flag stays low", 32'(comma_flag), 32'h0);
    endtask

    task automatic t_loopback();
        comma_en = 1'b0;
        loop_en = 1'b1;
        do_reset();
        push_word(W_ONE);
        check("R9 loopback word from tx", 32'(word_out), 32'(W_ONE));
        loop_en = 1'b0;
        push_word(W_TWO);
        check("R9 line word after loopback", 32'(word_out), 32'(W_TWO));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog got=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_free_run();
        t_align_pos();
        t_align_neg();
        t_disable();
        t_loopback();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule